// File: doc/BRIEF.md
# Per-Area External Bus Sequencer

This block runs external memory cycles for a processor whose address space is split into eight areas. The top three address bits pick the area. Each area keeps its own timing and width settings:

- a data bus width of 8 or 16 bits;
- a basic cycle of two or three clock states;
- a count of programmed wait states from 0 to 7;
- a flag that says whether the external wait input is honoured.

On the internal side a requester holds `req` together with the address, direction, size and write data until it sees a one-cycle `ack`. On the external side the block drives the address, write data, a read strobe, two byte-lane write strobes and one active-low chip select per area. It also samples an active-low wait input. The area settings are written through a small register port. A flag reports whether the bus must run in 16-bit mode.

A 16-bit request to an 8-bit area is carried out as two byte cycles. The upper byte comes first, at the even address. Two-state areas never insert waits. Three-state areas insert their programmed waits first, and then as many more waits as the wait input asks for.

Top module: `xbus_ctrl`

## Requirements
- R1: The area is `req_addr[23:21]`. During an access only `ext_cs_n[area]` is low. It stays low from the first state through the final state, including both halves of a split access. All chip selects are high when no access runs.
- R2: `bus16` is 1 when at least one area is set to 16 bits, and 0 when every area is set to 8 bits.
- R3: In a two-state area every bus cycle lasts exactly 2 clocks, and `ext_wait_n` has no effect.
- R4: In a three-state area with the wait input not asserted, a bus cycle lasts 3+P clocks, where P is the area's programmed wait count.
- R5: In a three-state area with wait honouring enabled, `ext_wait_n` is first sampled on the edge that ends the last programmed wait state (the edge that ends the second state when P=0). Each low sample adds one more wait state. With wait honouring disabled, the pin has no effect.
- R6: A 16-bit access to a 16-bit area is one bus cycle with address bit 0 forced to 0. Both write strobes are used, and data is passed on all 16 lines.
- R7: In a byte access, the data byte sits on the upper lane (bits 15:8) for an even address in a 16-bit area and for any address in an 8-bit area. It sits on the lower lane (bits 7:0) for an odd address in a 16-bit area. `ext_wr_n[1]` strobes the upper lane and `ext_wr_n[0]` the lower lane. The write byte is driven on both lanes. A byte read returns the byte in `rdata[7:0]` with `rdata[15:8]` = 0.
- R8: A 16-bit access to an 8-bit area makes two byte cycles, each with the area's full timing. The first is at the even address carrying `req_wdata[15:8]`, the second at the odd address carrying `req_wdata[7:0]`. A read returns {first byte, second byte}.
- R9: `ack` is high for exactly one clock, in the final state of the last bus cycle of a request, and `rdata` is valid in that clock.
- R10: After reset every area is 16 bits wide, three-state, with 7 programmed waits and wait honouring disabled.
- R11: When `cfg_we` is high, area `cfg_sel` takes `cfg_wdata`. The field layout is: bit 0 = 16-bit width, bit 1 = three-state, bit 2 = wait honouring, bits 5:3 = programmed wait count.
- R12: `req` is looked at only while idle. Each held request produces exactly one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Area setting write enable |
| cfg_sel | input | 3 | Area index for the setting write |
| cfg_wdata | input | 6 | Area setting fields |
| req | input | 1 | Access request, held until ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit access, 0 = byte |
| req_addr | input | 24 | Byte address |
| req_wdata | input | 16 | Write data (a byte uses bits 7:0) |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read data, valid with ack |
| bus16 | output | 1 | 16-bit bus mode flag |
| ext_addr | output | 24 | External address |
| ext_dout | output | 16 | External write data |
| ext_din | input | 16 | External read data |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 2 | Write strobes: [1] upper lane, [0] lower lane |
| ext_cs_n | output | 8 | Per-area chip selects, active low |
| ext_wait_n | input | 1 | External wait request, active low |

## Verification
Reads and writes are sent to areas that differ in only one setting at a time, so that a wrong cycle length points at a single cause:

- two-state against three-state;
- 0, 1, 2 and 7 programmed waits;
- wait honouring on against off.

The wait pin is held low for a varying number of clocks counted from the first state. Holding it below, at and beyond the sampling point shows whether the first sample lands on the correct edge. Holding it in two-state areas and in non-honouring areas shows that the pin is ignored there.

Byte accesses at even and odd addresses in 8-bit and 16-bit areas tell the two lanes and the two write strobes apart. Word accesses to 8-bit areas, with distinct upper and lower bytes, expose a swapped or merged split. The bus-mode flag is checked after configurations in which every area, and then exactly one area, is 16 bits wide.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned DATA_W = 2 * BYTE_W;
  localparam int unsigned WAIT_W = 3;

  typedef struct packed {
    logic [WAIT_W-1:0] pwait;
    logic              pin_en;
    logic              slow;
    logic              wide;
  } area_cfg_t;

  localparam int unsigned CFG_W = $bits(area_cfg_t);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_TW,
    ST_T3
  } bus_st_t;
endpackage

// File: rtl/xbus_cfg.sv
module xbus_cfg
  import xbus_pkg::*;
#(
  parameter int unsigned N_AREA = 8,
  localparam int unsigned SEL_W = $clog2(N_AREA)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  area_cfg_t        cfg_wdata,
  output area_cfg_t        cfg_q [N_AREA],
  output logic             bus16
);
  localparam area_cfg_t CFG_RST = '{pwait: '1, pin_en: 1'b0, slow: 1'b1, wide: 1'b1};

  area_cfg_t       regs_q [N_AREA];
  logic [N_AREA-1:0] hit;
  logic [N_AREA-1:0] wide_vec;

  for (genvar g = 0; g < N_AREA; g++) begin : g_area
    assign hit[g]      = cfg_we && (cfg_sel == SEL_W'(g));
    assign wide_vec[g] = regs_q[g].wide;
    assign cfg_q[g]    = regs_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_AREA; i++) regs_q[i] <= CFG_RST;
    end else begin
      for (int i = 0; i < N_AREA; i++) begin
        if (hit[i]) regs_q[i] <= cfg_wdata;
      end
    end
  end

  assign bus16 = |wide_vec;

  // R2: writing a 16-bit setting forces the 16-bit bus mode flag
  a_r2_bus_mode_on: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata.wide) |=> bus16);

  // R11: the written area holds exactly the written fields
  a_r11_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (regs_q[$past(cfg_sel)] == $past(cfg_wdata)));
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned AREA_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  area_cfg_t         cfg,
  input  logic              ext_wait_n,
  input  logic [BYTE_W-1:0] rbyte,
  output bus_st_t           st,
  output logic              half,
  output logic              split,
  output logic [ADDR_W-1:0] a_q,
  output logic              we_q,
  output logic              word_q,
  output logic [DATA_W-1:0] wd_q,
  output logic [BYTE_W-1:0] hi_q,
  output logic [AREA_W-1:0] area,
  output logic              ack
);
  bus_st_t           st_n;
  logic [WAIT_W-1:0] cnt, cnt_n;
  logic              half_n;
  logic              ld, hi_ld, final_st, wait_hit;

  assign area     = a_q[ADDR_W-1 -: AREA_W];
  assign split    = word_q & ~cfg.wide;
  assign final_st = ((st == ST_T2) && !cfg.slow) || (st == ST_T3);
  assign wait_hit = cfg.slow & cfg.pin_en & ~ext_wait_n;
  assign ack      = final_st & (~split | half);

  always_comb begin
    st_n   = st;
    cnt_n  = cnt;
    half_n = half;
    ld     = 1'b0;
    hi_ld  = 1'b0;
    unique case (st)
      ST_IDLE: if (req) begin
        st_n   = ST_T1;
        ld     = 1'b1;
        half_n = 1'b0;
      end
      ST_T1: st_n = ST_T2;
      ST_T2: if (cfg.slow) begin
        if (cfg.pwait != '0) begin
          st_n  = ST_TW;
          cnt_n = cfg.pwait - 1'b1;
        end else if (wait_hit) begin
          st_n  = ST_TW;
          cnt_n = '0;
        end else begin
          st_n = ST_T3;
        end
      end
      ST_TW: begin
        if (cnt != '0)     cnt_n = cnt - 1'b1;
        else if (!wait_hit) st_n = ST_T3;
      end
      ST_T3: st_n = ST_T3;
      default: st_n = ST_IDLE;
    endcase
    if (final_st) begin
      if (split && !half) begin
        st_n   = ST_T1;
        half_n = 1'b1;
        hi_ld  = 1'b1;
      end else begin
        st_n = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      half <= 1'b0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      half <= half_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      we_q   <= 1'b0;
      word_q <= 1'b0;
      wd_q   <= '0;
    end else if (ld) begin
      a_q    <= req_word ? {req_addr[ADDR_W-1:1], 1'b0} : req_addr;
      we_q   <= req_we;
      word_q <= req_word;
      wd_q   <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (hi_ld) hi_q <= rbyte;
  end

  // R3: a two-state cycle never continues into wait or third state
  a_r3_two_state: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_T2 && !cfg.slow) |=> (st == ST_IDLE || st == ST_T1));

  // R4: programmed waits are not cut short
  a_r4_prog_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TW && cnt != '0) |=> (st == ST_TW));

  // R5: without wait honouring, the pin cannot extend a cycle
  a_r5_pin_off: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TW && cnt == '0 && !cfg.pin_en) |=> (st == ST_T3));

  // R9: acknowledge lasts a single clock
  a_r9_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R12: the captured request stays put while an access runs
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |=> $stable(a_q));
endmodule

// File: rtl/xbus_lane.sv
module xbus_lane
  import xbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              active,
  input  logic              wide,
  input  logic              split,
  input  logic              half,
  input  logic [ADDR_W-1:0] a_q,
  input  logic              we_q,
  input  logic              word_q,
  input  logic [DATA_W-1:0] wd_q,
  input  logic [BYTE_W-1:0] hi_q,
  input  logic [DATA_W-1:0] ext_din,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_dout,
  output logic [1:0]        ext_wr_n,
  output logic              ext_rd_n,
  output logic [DATA_W-1:0] rdata,
  output logic [BYTE_W-1:0] rbyte
);
  logic              full16, upper;
  logic [BYTE_W-1:0] wbyte;

  always_comb begin
    full16   = word_q & wide;
    ext_addr = split ? {a_q[ADDR_W-1:1], half} : a_q;
    upper    = ~wide | ~ext_addr[0];
    wbyte    = (split && !half) ? wd_q[DATA_W-1:BYTE_W] : wd_q[BYTE_W-1:0];
    ext_dout = full16 ? wd_q : {wbyte, wbyte};
    if (!(active && we_q)) ext_wr_n = 2'b11;
    else if (full16)       ext_wr_n = 2'b00;
    else if (upper)        ext_wr_n = 2'b01;
    else                   ext_wr_n = 2'b10;
    ext_rd_n = ~(active & ~we_q);
    rbyte    = upper ? ext_din[DATA_W-1:BYTE_W] : ext_din[BYTE_W-1:0];
    if (full16)      rdata = ext_din;
    else if (word_q) rdata = {hi_q, rbyte};
    else             rdata = {{BYTE_W{1'b0}}, rbyte};
  end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
  import xbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned N_AREA = 8,
  localparam int unsigned AREA_W = $clog2(N_AREA)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [AREA_W-1:0] cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              req,
  input  logic              req_we,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic              bus16,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_dout,
  input  logic [DATA_W-1:0] ext_din,
  output logic              ext_rd_n,
  output logic [1:0]        ext_wr_n,
  output logic [N_AREA-1:0] ext_cs_n,
  input  logic              ext_wait_n
);
  logic [1:0]        sync_q;
  logic              rst_ns;
  area_cfg_t         cfg_q [N_AREA];
  area_cfg_t         cur;
  bus_st_t           st;
  logic              half, split, we_q, word_q, active;
  logic [ADDR_W-1:0] a_q;
  logic [DATA_W-1:0] wd_q;
  logic [BYTE_W-1:0] hi_q, rbyte;
  logic [AREA_W-1:0] area;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_ns = sync_q[1];

  xbus_cfg #(.N_AREA(N_AREA)) u_cfg (
    .clk(clk), .rst_n(rst_ns), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(area_cfg_t'(cfg_wdata)), .cfg_q(cfg_q), .bus16(bus16)
  );

  assign cur    = cfg_q[area];
  assign active = (st != ST_IDLE);

  xbus_seq #(.ADDR_W(ADDR_W), .AREA_W(AREA_W)) u_seq (
    .clk(clk), .rst_n(rst_ns), .req(req), .req_we(req_we), .req_word(req_word),
    .req_addr(req_addr), .req_wdata(req_wdata), .cfg(cur), .ext_wait_n(ext_wait_n),
    .rbyte(rbyte), .st(st), .half(half), .split(split), .a_q(a_q), .we_q(we_q),
    .word_q(word_q), .wd_q(wd_q), .hi_q(hi_q), .area(area), .ack(ack)
  );

  xbus_lane #(.ADDR_W(ADDR_W)) u_lane (
    .active(active), .wide(cur.wide), .split(split), .half(half), .a_q(a_q),
    .we_q(we_q), .word_q(word_q), .wd_q(wd_q), .hi_q(hi_q), .ext_din(ext_din),
    .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_wr_n(ext_wr_n),
    .ext_rd_n(ext_rd_n), .rdata(rdata), .rbyte(rbyte)
  );

  always_comb begin
    ext_cs_n = '1;
    if (active) ext_cs_n[area] = 1'b0;
  end

  // R1: never more than one chip select low
  a_r1_cs_single: assert property (@(posedge clk) disable iff (!rst_ns)
    $onehot0(~ext_cs_n));

  // R1: the acknowledged access used the chip select of its area
  a_r1_cs_area: assert property (@(posedge clk) disable iff (!rst_ns)
    ack |-> (ext_cs_n[ext_addr[ADDR_W-1 -: AREA_W]] == 1'b0));

  // R6: a full-width access presents an even address
  a_r6_even: assert property (@(posedge clk) disable iff (!rst_ns)
    (!ext_rd_n && ext_wr_n == 2'b11 && ack && word_q && cur.wide) |-> !ext_addr[0]);
endmodule

// File: tb/xbus_ctrl_tb.sv
module xbus_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_sel;
  logic [5:0]  cfg_wdata;
  logic        req, req_we, req_word;
  logic [23:0] req_addr;
  logic [15:0] req_wdata;
  logic        ack;
  logic [15:0] rdata;
  logic        bus16;
  logic [23:0] ext_addr;
  logic [15:0] ext_dout;
  logic [15:0] ext_din;
  logic        ext_rd_n;
  logic [1:0]  ext_wr_n;
  logic [7:0]  ext_cs_n;
  logic        ext_wait_n;

  always #4 clk = ~clk;

  xbus_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .req(req), .req_we(req_we), .req_word(req_word), .req_addr(req_addr),
    .req_wdata(req_wdata), .ack(ack), .rdata(rdata), .bus16(bus16),
    .ext_addr(ext_addr), .ext_dout(ext_dout), .ext_din(ext_din), .ext_rd_n(ext_rd_n),
    .ext_wr_n(ext_wr_n), .ext_cs_n(ext_cs_n), .ext_wait_n(ext_wait_n)
  );

  typedef struct {
    int          len;
    int          area;
    bit          rd;
    logic [15:0] rdata;
    logic [23:0] fa, la;
    logic [15:0] fd, ld;
    logic [1:0]  fw, lw;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   nchk = 0, nerr = 0, nreq = 0, nacc = 0, cyc = 0, cur_k = 0;
  bit   sh_wide [8], sh_slow [8], sh_pen [8];
  int   sh_pw [8];
  bit   rst_done = 0, done = 0, cs_bad;
  logic [23:0] f_a;
  logic [15:0] f_d;
  logic [1:0]  f_w;
  logic        f_r;

  function automatic logic [7:0] mb(logic [23:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  // external memory model: a 16-bit area answers on both lanes, an 8-bit one on the upper lane
  always_comb begin
    if (sh_wide[ext_addr[23:21]]) ext_din = {mb({ext_addr[23:1], 1'b0}), mb({ext_addr[23:1], 1'b1})};
    else                          ext_din = {mb(ext_addr), 8'hEE};
  end

  task automatic chk(bit ok, string what, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  endtask

  // monitor: counts chip-select clocks, drives the wait pin, compares at ack
  always @(negedge clk) begin
    if (!rst_done) begin
      ext_wait_n = 1'b1;
    end else if (ext_cs_n != 8'hFF) begin
      cyc++;
      if (cyc == 1) begin
        f_a = ext_addr; f_d = ext_dout; f_w = ext_wr_n; f_r = ext_rd_n; cs_bad = 0;
      end
      if (q.size() > 0 && ext_cs_n != ~(8'd1 << q[0].area)) cs_bad = 1;
      ext_wait_n = !(cyc <= cur_k);
      if (ack) begin
        exp_t e;
        if (q.size() == 0) begin
          chk(0, "R12 ack with nothing outstanding", 32'(nacc), 32'(nreq));
        end else begin
          e = q.pop_front();
          chk(!cs_bad, {e.tag, " R1 chip select"}, 32'(ext_cs_n), 32'(~(8'd1 << e.area)));
          chk(cyc == e.len, {e.tag, " cycle length"}, 32'(cyc), 32'(e.len));
          chk(f_a == e.fa, {e.tag, " first address"}, 32'(f_a), 32'(e.fa));
          chk(ext_addr == e.la, {e.tag, " last address"}, 32'(ext_addr), 32'(e.la));
          chk(f_r == !e.rd, {e.tag, " read strobe"}, 32'(f_r), 32'(!e.rd));
          chk(f_w == e.fw && ext_wr_n == e.lw, {e.tag, " write strobes"},
              32'({f_w, ext_wr_n}), 32'({e.fw, e.lw}));
          if (e.rd) chk(rdata == e.rdata, {e.tag, " R9 rdata at ack"}, 32'(rdata), 32'(e.rdata));
          else      chk(f_d == e.fd && ext_dout == e.ld, {e.tag, " write data"},
                        32'({f_d, ext_dout}), 32'({e.fd, e.ld}));
        end
        nacc++;
        cyc = 0;
        ext_wait_n = 1'b1;
      end
    end else begin
      ext_wait_n = 1'b1;
      if (ack) chk(0, "R9 ack while no chip select", 32'(ack), 32'(0));
      if (cyc != 0) begin
        chk(0, "R1 chip select dropped before ack", 32'(cyc), 32'(0));
        cyc = 0;
      end
    end
  end

  task automatic set_cfg(int ar, bit wide, bit slow, bit pen, int pw);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 3'(ar); cfg_wdata = {3'(pw), pen, slow, wide};
    @(negedge clk);
    cfg_we = 0;
    sh_wide[ar] = wide; sh_slow[ar] = slow; sh_pen[ar] = pen; sh_pw[ar] = pw;
  endtask

  task automatic acc(int ar, logic [20:0] off, bit w, bit word, logic [15:0] wd, int k, string tag);
    exp_t e;
    int   base;
    bit   sp;
    logic [23:0] a;
    a = {3'(ar), off};
    if (word) a[0] = 1'b0;
    sp   = word && !sh_wide[ar];
    base = sh_slow[ar] ? 3 + sh_pw[ar] : 2;
    if (sh_slow[ar] && sh_pen[ar] && k >= 2 + sh_pw[ar]) base = k + 2;
    e.len = sp ? 2 * base : base;
    e.area = ar; e.rd = !w; e.tag = tag;
    e.fa = a; e.la = sp ? {a[23:1], 1'b1} : a;
    if (word)         e.rdata = {mb(a), mb({a[23:1], 1'b1})};
    else              e.rdata = {8'h00, mb(a)};
    if (word && !sp) begin e.fd = wd; e.ld = wd; end
    else if (sp)     begin e.fd = {wd[15:8], wd[15:8]}; e.ld = {wd[7:0], wd[7:0]}; end
    else             begin e.fd = {wd[7:0], wd[7:0]}; e.ld = e.fd; end
    if (!w)                   e.fw = 2'b11;
    else if (word && !sp)     e.fw = 2'b00;
    else if (sh_wide[ar] && a[0] && !word) e.fw = 2'b10;
    else                      e.fw = 2'b01;
    e.lw = e.fw;
    q.push_back(e);
    cur_k = k;
    @(negedge clk);
    req = 1; req_we = w; req_word = word; req_addr = {3'(ar), off}; req_wdata = wd;
    do begin @(posedge clk); #2; end while (!ack);
    req = 0;
    nreq++;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    chk(0, "watchdog expired", 0, 0);
    finish_run();
  end

  initial begin
    rst_n = 0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    req = 0; req_we = 0; req_word = 0; req_addr = 0; req_wdata = 0;
    for (int i = 0; i < 8; i++) begin
      sh_wide[i] = 1; sh_slow[i] = 1; sh_pen[i] = 0; sh_pw[i] = 7;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    rst_done = 1;
    // R10 / R1 / R2: state after reset
    chk(ext_cs_n == 8'hFF, "R1 chip selects idle after reset", 32'(ext_cs_n), 32'hFF);
    chk(!ack && ext_rd_n && ext_wr_n == 2'b11, "R10 strobes idle after reset",
        32'({ack, ext_rd_n, ext_wr_n}), 32'b0111);
    chk(bus16 == 1, "R2 R10 16-bit mode after reset", 32'(bus16), 1);
    // R10 R6: default area is 16-bit, 3-state, 7 waits, pin ignored
    acc(0, 21'h000010, 0, 1, 16'h0, 5, "R10 R6 default word read");
    acc(0, 21'h000033, 0, 1, 16'h0, 0, "R6 odd word address forced even");
    acc(0, 21'h000022, 1, 1, 16'h1234, 0, "R6 full word write");
    acc(0, 21'h000011, 1, 0, 16'h00A7, 0, "R7 byte write odd 16-bit area");
    acc(0, 21'h000012, 1, 0, 16'h003C, 0, "R7 byte write even 16-bit area");
    // R11 R3 R8: 8-bit two-state area
    set_cfg(1, 0, 0, 0, 0);
    chk(bus16 == 1, "R2 mixed widths stay 16-bit", 32'(bus16), 1);
    acc(1, 21'h000100, 0, 1, 16'h0, 0, "R8 R3 split word read");
    acc(1, 21'h000123, 1, 0, 16'h0055, 5, "R3 R7 byte write pin ignored");
    acc(1, 21'h000200, 1, 1, 16'hBEEF, 0, "R8 split word write");
    // R4 R5: programmed waits plus pin
    set_cfg(2, 1, 1, 1, 2);
    acc(2, 21'h000300, 0, 1, 16'h0, 0, "R4 two programmed waits");
    acc(2, 21'h000300, 0, 1, 16'h0, 3, "R5 pin released before sample");
    acc(2, 21'h000300, 0, 1, 16'h0, 4, "R5 pin low at first sample");
    acc(2, 21'h000300, 0, 1, 16'h0, 7, "R5 pin held long");
    acc(2, 21'h000040, 0, 0, 16'h0, 0, "R7 byte read even 16-bit area");
    acc(2, 21'h000041, 0, 0, 16'h0, 0, "R7 byte read odd 16-bit area");
    set_cfg(3, 1, 1, 0, 0);
    acc(3, 21'h000400, 0, 1, 16'h0, 6, "R5 pin disabled no effect");
    set_cfg(3, 1, 1, 1, 0);
    acc(3, 21'h000400, 0, 1, 16'h0, 4, "R5 zero waits pin sampled after T2");
    acc(3, 21'h000400, 0, 1, 16'h0, 1, "R5 pin low only in T1");
    // R8: split in a three-state area, each half full length
    set_cfg(4, 0, 1, 0, 1);
    acc(4, 21'h000502, 0, 1, 16'h0, 0, "R8 R4 split three-state read");
    acc(4, 21'h000507, 0, 0, 16'h0, 0, "R7 byte read 8-bit area");
    // R2: all 8-bit then one 16-bit
    for (int i = 0; i < 8; i++) set_cfg(i, 0, sh_slow[i], sh_pen[i], sh_pw[i]);
    chk(bus16 == 0, "R2 all areas 8-bit", 32'(bus16), 0);
    set_cfg(5, 1, 1, 0, 0);
    chk(bus16 == 1, "R2 one area 16-bit", 32'(bus16), 1);
    acc(5, 21'h000600, 0, 1, 16'h0, 0, "R11 R4 reconfigured area");
    repeat (4) @(negedge clk);
    // R12: one access per request
    chk(nacc == nreq && q.size() == 0, "R12 accesses per request", 32'(nacc), 32'(nreq));
    finish_run();
  end
endmodule